// File: doc/BRIEF.md
# Serial Audio Frame Receiver

The receiver turns a three-wire serial audio stream into parallel stereo samples. Its inputs are a bit clock, a word clock and a data line. All three are oversampled in the system clock domain through synchronisers. A serial bit is taken at each rising edge of the bit clock that the synchroniser detects. A static format input selects one of two framings. In one, a low word clock marks the left channel and the most significant bit trails the word-clock change by one bit clock. In the other, a high word clock marks the left channel and the most significant bit arrives with the change.

A static word-length input selects 16, 24 or 32 data bits per channel. Every half-frame is measured in bit clocks and checked against the allowed slot sizes. A frame with two good halves is delivered as two left-aligned 32-bit words together with a one-cycle strobe. A run of bad frames raises an error flag and forces both outputs to the zero code. The run is longer than a set limit, four frames by default. The first good frame after that clears the flag.

Top module: `serial_audio_rx`

## Requirements
- R1: After reset, `left_q` and `right_q` are zero, and `frame_vld` and `frame_err` are low.
- R2: With `fmt_lj` = 1, a high word clock marks the left channel. The data bit taken at the first bit-clock rise after the word clock changes is the most significant bit.
- R3: With `fmt_lj` = 0, a low word clock marks the left channel. The most significant bit is taken at the second bit-clock rise after the word clock changes, so the word clock leads the data by one bit.
- R4: `wlen` selects the word length: 2'b00 gives 16 bits, 2'b01 gives 24 bits, and 2'b10 or 2'b11 gives 32 bits. A delivered word is left-aligned, with its most significant bit at bit 31 and zeros below its least significant bit.
- R5: Slot bits past the selected word length have no effect on the delivered word.
- R6: A half-frame is good only when its length is 16, 24 or 32 bit clocks and is at least the word length. A frame with a bad half produces no strobe and leaves `left_q` and `right_q` unchanged, unless R8 applies.
- R7: When a frame with two good halves completes, `frame_vld` pulses for exactly one cycle, and `left_q` and `right_q` take the new words in that same cycle.
- R8: When the number of consecutive bad frames exceeds ERR_LIMIT (default 4), `frame_err` goes high and `left_q` and `right_q` are forced to zero. They stay zero while bad frames continue.
- R9: A good frame that arrives while `frame_err` is high clears the flag in the cycle its words are delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk_in | input | 1 | Serial bit clock, asynchronous to clk |
| ws_in | input | 1 | Word (channel) clock |
| sd_in | input | 1 | Serial data line |
| fmt_lj | input | 1 | Framing select: 1 gives left-justified, 0 gives I2S |
| wlen | input | 2 | Word length code |
| left_q | output | 32 | Left-channel word, left-aligned |
| right_q | output | 32 | Right-channel word, left-aligned |
| frame_vld | output | 1 | One-cycle strobe when a frame is delivered |
| frame_err | output | 1 | Framing error: outputs are muted |

## Verification
Frame delivery and the error counter act at the same word-clock boundary. A good frame that arrives while `frame_err` is high must clear the flag and load new words in one cycle, with the mute never winning. The bench provokes this case with a stream of too-long half-frames that raises the error, followed directly by good frames. It judges the result by requiring a cleared flag together with the exact words of the first good frame. The bench also sweeps both framings, all three word lengths and all three slot sizes. In every combination it either expects the arithmetically aligned words or expects no delivery.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int unsigned SAMPLE_W = 32;

  typedef enum logic [1:0] {
    WL_16  = 2'b00,
    WL_24  = 2'b01,
    WL_32  = 2'b10,
    WL_32B = 2'b11
  } wlen_e;

  // Data bits carried per channel for a word-length code.
  function automatic int unsigned word_bits(input logic [1:0] wl);
    case (wl)
      WL_16:   return 16;
      WL_24:   return 24;
      default: return 32;
    endcase
  endfunction

  // A half-frame is acceptable when its slot size is allowed and holds the word.
  function automatic logic slot_ok(input int unsigned len, input logic [1:0] wl);
    return ((len == 16) || (len == 24) || (len == 32)) && (len >= word_bits(wl));
  endfunction
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic ws_in,
  input  logic sd_in,
  output logic bit_ev,
  output logic ws_b,
  output logic sd_b
);
  logic [STAGES:0]   sclk_p;
  logic [STAGES-1:0] ws_p;
  logic [STAGES-1:0] sd_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_p <= '0;
      ws_p   <= '0;
      sd_p   <= '0;
    end else begin
      sclk_p <= {sclk_p[STAGES-1:0], sclk_in};
      ws_p   <= {ws_p[STAGES-2:0], ws_in};
      sd_p   <= {sd_p[STAGES-2:0], sd_in};
    end
  end

  // Word clock and data are delayed by the same depth as the sampled bit clock.
  assign bit_ev = sclk_p[STAGES-1] & ~sclk_p[STAGES];
  assign ws_b   = ws_p[STAGES-1];
  assign sd_b   = sd_p[STAGES-1];
endmodule

// File: rtl/sar_framer.sv
module sar_framer import sar_pkg::*; #(
  parameter int CNT_W = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_ev,
  input  logic                ws_b,
  input  logic                sd_b,
  input  logic                fmt_lj,
  input  logic [1:0]          wlen,
  output logic                half_done,
  output logic                half_left,
  output logic                half_ok,
  output logic [SAMPLE_W-1:0] half_word
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic                ws_dly_q, prev_eff_q, armed_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [SAMPLE_W-1:0] shift_q;

  logic                eff_ws, word_edge;
  logic [CNT_W-1:0]    idx, cnt_n;
  logic [SAMPLE_W-1:0] shift_n;

  // I2S is turned into left-justified timing by delaying the word clock one bit.
  assign eff_ws    = fmt_lj ? ws_b : ws_dly_q;
  assign word_edge = bit_ev && (eff_ws != prev_eff_q);
  assign idx       = word_edge ? '0 : cnt_q;
  assign cnt_n     = (idx == CNT_MAX) ? CNT_MAX : idx + 1'b1;

  always_comb begin
    shift_n = word_edge ? '0 : shift_q;
    if (32'(idx) < word_bits(wlen))
      shift_n[SAMPLE_W-1-int'(idx)] = sd_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_dly_q   <= 1'b0;
      prev_eff_q <= 1'b0;
      armed_q    <= 1'b0;
      cnt_q      <= CNT_MAX;
      shift_q    <= '0;
      half_done  <= 1'b0;
      half_left  <= 1'b0;
      half_ok    <= 1'b0;
      half_word  <= '0;
    end else begin
      half_done <= word_edge && armed_q;
      if (bit_ev) begin
        ws_dly_q   <= ws_b;
        prev_eff_q <= eff_ws;
        cnt_q      <= cnt_n;
        shift_q    <= shift_n;
      end
      if (word_edge) begin
        armed_q   <= 1'b1;
        half_left <= fmt_lj ? prev_eff_q : ~prev_eff_q;
        half_ok   <= slot_ok(32'(cnt_q), wlen);
        half_word <= shift_q;
      end
    end
  end

  AST_HALF_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    half_done |=> !half_done); // R6
endmodule

// File: rtl/sar_judge.sv
module sar_judge import sar_pkg::*; #(
  parameter int ERR_LIMIT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                half_done,
  input  logic                half_left,
  input  logic                half_ok,
  input  logic [SAMPLE_W-1:0] half_word,
  output logic [SAMPLE_W-1:0] left_q,
  output logic [SAMPLE_W-1:0] right_q,
  output logic                frame_vld,
  output logic                frame_err
);
  localparam int             BAD_W   = $clog2(ERR_LIMIT + 2);
  localparam logic [BAD_W-1:0] BAD_MAX = BAD_W'(ERR_LIMIT + 1);

  logic                left_ok_q;
  logic [SAMPLE_W-1:0] left_buf_q;
  logic [BAD_W-1:0]    bad_q, bad_n;
  logic                frame_end, frame_good, frame_bad, err_trip;

  assign frame_end  = half_done && !half_left;
  assign frame_good = frame_end && left_ok_q && half_ok;
  assign frame_bad  = frame_end && !frame_good;
  assign bad_n      = (bad_q == BAD_MAX) ? bad_q : bad_q + 1'b1;
  assign err_trip   = 32'(bad_n) > ERR_LIMIT;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_ok_q  <= 1'b0;
      left_buf_q <= '0;
      bad_q      <= '0;
      left_q     <= '0;
      right_q    <= '0;
      frame_vld  <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      frame_vld <= frame_good;
      if (half_done && half_left) begin
        left_ok_q  <= half_ok;
        left_buf_q <= half_word;
      end
      if (frame_end) left_ok_q <= 1'b0;
      if (frame_good) begin
        left_q    <= left_buf_q;
        right_q   <= half_word;
        bad_q     <= '0;
        frame_err <= 1'b0;
      end else if (frame_bad) begin
        bad_q <= bad_n;
        if (err_trip) begin
          frame_err <= 1'b1;
          left_q    <= '0;
          right_q   <= '0;
        end
      end
    end
  end

  AST_MUTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> (left_q == '0) && (right_q == '0)); // R8
  AST_VLD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |=> !frame_vld); // R7
  AST_VLD_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |-> !frame_err); // R9
  AST_HOLD_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_vld && !$rose(frame_err)) |-> ($stable(left_q) && $stable(right_q))); // R6
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx import sar_pkg::*; #(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 6,
  parameter int ERR_LIMIT   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk_in,
  input  logic        ws_in,
  input  logic        sd_in,
  input  logic        fmt_lj,
  input  logic [1:0]  wlen,
  output logic [31:0] left_q,
  output logic [31:0] right_q,
  output logic        frame_vld,
  output logic        frame_err
);
  logic                bit_ev, ws_b, sd_b;
  logic                half_done, half_left, half_ok;
  logic [SAMPLE_W-1:0] half_word;

  sar_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .ws_in(ws_in), .sd_in(sd_in),
    .bit_ev(bit_ev), .ws_b(ws_b), .sd_b(sd_b)
  );

  sar_framer #(.CNT_W(CNT_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .bit_ev(bit_ev), .ws_b(ws_b), .sd_b(sd_b),
    .fmt_lj(fmt_lj), .wlen(wlen),
    .half_done(half_done), .half_left(half_left), .half_ok(half_ok),
    .half_word(half_word)
  );

  sar_judge #(.ERR_LIMIT(ERR_LIMIT)) u_judge (
    .clk(clk), .rst_n(rst_n), .half_done(half_done), .half_left(half_left),
    .half_ok(half_ok), .half_word(half_word),
    .left_q(left_q), .right_q(right_q), .frame_vld(frame_vld), .frame_err(frame_err)
  );
endmodule

// File: tb/serial_audio_rx_tb_top.sv
`timescale 1ns/1ps
module serial_audio_rx_tb_top;
  localparam int H = 4; // system clocks per bit-clock phase

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk_in = 1'b0, ws_in = 1'b0, sd_in = 1'b0, fmt_lj = 1'b0;
  logic [1:0]  wlen = 2'b00;
  logic [31:0] left_q, right_q;
  logic        frame_vld, frame_err;

  int n_chk = 0, n_bad = 0, vld_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serial_audio_rx dut_i (
    .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .ws_in(ws_in), .sd_in(sd_in),
    .fmt_lj(fmt_lj), .wlen(wlen), .left_q(left_q), .right_q(right_q),
    .frame_vld(frame_vld), .frame_err(frame_err)
  );

  always_ff @(posedge clk) if (frame_vld) vld_cnt <= vld_cnt + 1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] gen_word(input int seed, input int wbits);
    logic [31:0] w;
    w = (32'h9E37_79B9 * 32'(seed + 1)) ^ (32'(seed) << 13) ^ 32'h5A5A_0F0F;
    return (wbits == 32) ? w : (w & ((32'd1 << wbits) - 1));
  endfunction

  function automatic logic [31:0] aligned(input logic [31:0] w, input int wbits);
    return w << (32 - wbits);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; sclk_in = 1'b0; ws_in = 1'b0; sd_in = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic drive_slot(input logic ws, input logic sd);
    sclk_in = 1'b0; ws_in = ws; sd_in = sd;
    repeat (H) @(negedge clk);
    sclk_in = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  // Pad bits past the word are driven high so that R5 is exercised.
  task automatic send_half(input logic is_left, input int bph, input logic [31:0] w, input int wbits);
    for (int k = 0; k < bph; k++) begin
      logic ws, sd;
      if (fmt_lj) ws = is_left;
      else        ws = (k == bph - 1) ? is_left : !is_left;
      sd = (k < wbits) ? w[wbits - 1 - k] : 1'b1;
      drive_slot(ws, sd);
    end
  endtask

  task automatic send_frame(input logic [31:0] l, input logic [31:0] r, input int bph, input int wbits);
    send_half(1'b1, bph, l, wbits);
    send_half(1'b0, bph, r, wbits);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int base;
    logic [31:0] l2, r2, g0l, g0r;
    do_reset();
    check("R1 left_q", left_q, 32'h0);
    check("R1 right_q", right_q, 32'h0);
    check("R1 frame_vld", {31'h0, frame_vld}, 32'h0);
    check("R1 frame_err", {31'h0, frame_err}, 32'h0);

    // Sweep of framing x word length x slot size.
    for (int f = 0; f < 2; f++) begin
      for (int wi = 0; wi < 3; wi++) begin
        for (int bi = 0; bi < 3; bi++) begin
          int wbits, bph, sb;
          bit good;
          string tg;
          wbits = 16 + 8 * wi;
          bph   = 16 + 8 * bi;
          good  = (bph >= wbits);
          sb    = 16 * (bi + 3 * (wi + 3 * f));
          fmt_lj = f[0];
          wlen   = 2'(wi);
          tg = f ? "R2/R4/R5" : "R3/R4/R5";
          do_reset();
          for (int fr = 0; fr < 2; fr++)
            send_frame(gen_word(sb + 2*fr, wbits), gen_word(sb + 2*fr + 1, wbits), bph, wbits);
          for (int fr = 2; fr < 4; fr++) begin
            base = vld_cnt;
            send_frame(gen_word(sb + 2*fr, wbits), gen_word(sb + 2*fr + 1, wbits), bph, wbits);
            if (good) begin
              check("R7 strobe count", 32'(vld_cnt - base), 32'd1);
              check({tg, " left"},  left_q,  aligned(gen_word(sb + 2*fr - 2, wbits), wbits));
              check({tg, " right"}, right_q, aligned(gen_word(sb + 2*fr - 1, wbits), wbits));
            end else begin
              check("R6 no strobe", 32'(vld_cnt - base), 32'd0);
              check("R6 left unchanged", left_q, 32'h0);
              check("R6 right unchanged", right_q, 32'h0);
            end
          end
        end
      end
    end

    // Error run followed by recovery, left-justified, 16-bit words in 16-bit slots.
    fmt_lj = 1'b1; wlen = 2'b00;
    do_reset();
    send_frame(gen_word(900, 16), gen_word(901, 16), 16, 16);
    send_frame(gen_word(902, 16), gen_word(903, 16), 16, 16);
    l2 = gen_word(904, 16); r2 = gen_word(905, 16);
    send_frame(l2, r2, 16, 16);
    base = vld_cnt;
    for (int b = 0; b < 4; b++) send_frame(gen_word(950 + b, 16), gen_word(960 + b, 16), 20, 16);
    check("R6 strobes during short bad run", 32'(vld_cnt - base), 32'd1);
    check("R6 err low after 3 bad frames", {31'h0, frame_err}, 32'h0);
    check("R6 left held", left_q, aligned(l2, 16));
    check("R6 right held", right_q, aligned(r2, 16));
    send_frame(gen_word(970, 16), gen_word(971, 16), 20, 16);
    send_frame(gen_word(972, 16), gen_word(973, 16), 20, 16);
    check("R8 err high after 5 bad frames", {31'h0, frame_err}, 32'h1);
    check("R8 left muted", left_q, 32'h0);
    check("R8 right muted", right_q, 32'h0);
    g0l = gen_word(980, 16); g0r = gen_word(981, 16);
    base = vld_cnt;
    send_frame(g0l, g0r, 16, 16);
    check("R8 still muted before good frame closes", left_q, 32'h0);
    send_frame(gen_word(982, 16), gen_word(983, 16), 16, 16);
    check("R9 err cleared", {31'h0, frame_err}, 32'h0);
    check("R9 strobe", 32'(vld_cnt - base), 32'd1);
    check("R9 left", left_q, aligned(g0l, 16));
    check("R9 right", right_q, aligned(g0r, 16));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule